// File: doc/BRIEF.md
# PLL Divider Settings Calculator

This block turns a requested output frequency and a reference frequency, both unsigned 32-bit integers in hertz, into PLL settings. It picks a power-of-two post divider and a fixed-point feedback word. It also returns the output frequency that those settings actually give, so software can compare it with the request.

The feedback word always has 7 integer bits. Any bits beyond 7 in the configured word width are fractional. The quotient comes from a restoring divider that produces one quotient bit per cycle. The block therefore runs as a sequential unit with a `start`/`done` handshake. The word width, the frequency ceiling and the VCO floor are parameters.

Top module: `pll_calc`

## Requirements
- R1: After reset, `done`, `busy` and `err` are low, and `pcw`, `pdiv_code` and `rate` are zero.
- R2: A requested frequency above `FMAX` is replaced by `FMAX` before any other step.
- R3: `pdiv_code` is the smallest value c in 0..4 such that (frequency × 2^c) ≥ `FMIN_VCO`. If no such value exists, `pdiv_code` is 4. The post divider is 2^`pdiv_code`.
- R4: `pcw` equals the low `PCW_W` bits of floor((frequency × 2^`pdiv_code` × 2^F) / reference). F is `PCW_W` − 7 when `PCW_W` > 7, and 0 otherwise.
- R5: The VCO value is the 64-bit product reference × `pcw`, shifted right by F. If any of the F bits shifted out are nonzero, 1 is added to the result.
- R6: `rate` equals ceil(VCO / 2^`pdiv_code`).
- R7: `done` is high for exactly one cycle per accepted start, and `busy` is low in that cycle. For a nonzero reference, `busy` is high from the cycle after `start` until `done`.
- R8: A reference of zero gives `err` = 1 with `pcw`, `pdiv_code` and `rate` all zero. In that case `done` pulses in the cycle after `start`, and no division is performed.
- R9: A `start` that arrives while `busy` is high is ignored. It produces no extra `done`, and the result still belongs to the earlier request.
- R10: `pcw`, `pdiv_code`, `rate` and `err` change only in a cycle where `done` is high. Between results they hold, even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a calculation, sampled while idle |
| req_hz | input | 32 | Requested output frequency |
| ref_hz | input | 32 | Reference input frequency |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Reference was zero |
| pcw | output | PCW_W | Feedback divider word (7 integer bits + F fraction bits) |
| pdiv_code | output | 3 | log2 of the post divider |
| rate | output | 64 | Achieved output frequency |

## Verification
The bench builds two instances from the same stimulus. One uses a 24-bit word, which gives 17 fractional bits and exercises the round-up on discarded fraction bits. The other uses a 7-bit word, which gives no fraction and also truncates the quotient to its low bits when the reference is small. The frequency ceiling is 2 GHz and the VCO floor is 1 GHz. With these values, requests that land exactly on the floor after 0 to 4 doublings can be tested, along with requests that stay below it after 16x and requests clamped from above.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

  localparam int INT_BITS = 7;
  localparam int MAX_CODE = 4;

  // Requested frequency limited to the ceiling
  function automatic logic [31:0] clamp_hz(input logic [31:0] f, input logic [31:0] ceil_hz);
    return (f > ceil_hz) ? ceil_hz : f;
  endfunction

  // Smallest shift 0..MAX_CODE that lifts f to the VCO floor, else MAX_CODE
  function automatic logic [2:0] pick_code(input logic [31:0] f, input logic [31:0] floor_hz);
    logic [2:0] c;
    c = 3'(MAX_CODE);
    for (int i = MAX_CODE; i >= 0; i--) begin
      if (({32'd0, f} << i) >= {32'd0, floor_hz}) c = 3'(i);
    end
    return c;
  endfunction

  // Ceiling division by 2**code
  function automatic logic [63:0] ceil_pow2(input logic [63:0] v, input logic [2:0] code);
    return (v + ((64'd1 << code) - 64'd1)) >> code;
  endfunction

endpackage

// File: rtl/pll_calc_div.sv
module pll_calc_div #(
  parameter int DVD_W  = 64,
  parameter int DVS_W  = 32,
  parameter int QOUT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DVD_W-1:0]  dividend,
  input  logic [DVS_W-1:0]  divisor,
  output logic              running,
  output logic              fin,
  output logic [QOUT_W-1:0] quot
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] work_q;   // dividend bits shift out the top, quotient bits in the bottom
  logic [DVS_W-1:0] rem_q;
  logic [DVS_W-1:0] dvs_q;
  logic [CNT_W-1:0] cnt_q;

  logic [DVS_W:0]   rem_sh;
  logic [DVS_W:0]   diff;
  logic             fits;
  logic [DVS_W-1:0] rem_nx;

  always_comb begin
    rem_sh = {rem_q, work_q[DVD_W-1]};
    diff   = rem_sh - {1'b0, dvs_q};
    fits   = !diff[DVS_W];
    rem_nx = fits ? diff[DVS_W-1:0] : rem_sh[DVS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q  <= '0;
      rem_q   <= '0;
      dvs_q   <= '0;
      cnt_q   <= '0;
      running <= 1'b0;
      fin     <= 1'b0;
    end else if (load) begin
      work_q  <= dividend;
      rem_q   <= '0;
      dvs_q   <= divisor;
      cnt_q   <= '0;
      running <= 1'b1;
      fin     <= 1'b0;
    end else if (running) begin
      work_q <= {work_q[DVD_W-2:0], fits};
      rem_q  <= rem_nx;
      cnt_q  <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(DVD_W - 1)) begin
        running <= 1'b0;
        fin     <= 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  assign quot = work_q[QOUT_W-1:0];

  // Restoring step keeps the partial remainder below the divisor
  assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (rem_q < dvs_q));

  assert_fin_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);

endmodule

// File: rtl/pll_calc_rate.sv
module pll_calc_rate #(
  parameter int PCW_W  = 24,
  parameter int FRAC_W = 17
) (
  input  logic [31:0]      ref_hz,
  input  logic [PCW_W-1:0] pcw,
  input  logic [2:0]       code,
  output logic [63:0]      rate
);
  import pll_calc_pkg::*;

  logic [63:0] vco;
  logic [63:0] vco_red;

  assign vco = 64'(ref_hz) * 64'(pcw);

  generate
    if (FRAC_W > 0) begin : g_frac
      // drop fraction, round up when anything nonzero is dropped
      assign vco_red = (vco >> FRAC_W) + {63'd0, |vco[FRAC_W-1:0]};
    end else begin : g_int
      assign vco_red = vco;
    end
  endgenerate

  assign rate = ceil_pow2(vco_red, code);

endmodule

// File: rtl/pll_calc.sv
module pll_calc #(
  parameter int          PCW_W    = 24,
  parameter logic [31:0] FMAX     = 32'd2000000000,
  parameter logic [31:0] FMIN_VCO = 32'd1000000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      req_hz,
  input  logic [31:0]      ref_hz,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [PCW_W-1:0] pcw,
  output logic [2:0]       pdiv_code,
  output logic [63:0]      rate
);
  import pll_calc_pkg::*;

  localparam int FRAC_W = (PCW_W > INT_BITS) ? PCW_W - INT_BITS : 0;
  localparam int DVD_W  = 64;
  localparam int DVS_W  = 32;

  // Named events
  logic accept;
  logic zero_ref;
  logic div_load;
  logic div_fin;
  logic div_run;

  logic [31:0]      freq_c;
  logic [2:0]       code_c;
  logic [63:0]      dvd_c;
  logic [PCW_W-1:0] quot;
  logic [63:0]      rate_c;

  logic [31:0] ref_q;
  logic [2:0]  code_q;

  assign accept   = start && !busy;
  assign zero_ref = (ref_hz == 32'd0);
  assign div_load = accept && !zero_ref;

  assign freq_c = clamp_hz(req_hz, FMAX);
  assign code_c = pick_code(freq_c, FMIN_VCO);
  assign dvd_c  = (64'(freq_c) << code_c) << FRAC_W;

  pll_calc_div #(.DVD_W(DVD_W), .DVS_W(DVS_W), .QOUT_W(PCW_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (div_load),
    .dividend (dvd_c),
    .divisor  (ref_hz),
    .running  (div_run),
    .fin      (div_fin),
    .quot     (quot)
  );

  pll_calc_rate #(.PCW_W(PCW_W), .FRAC_W(FRAC_W)) u_rate (
    .ref_hz (ref_q),
    .pcw    (quot),
    .code   (code_q),
    .rate   (rate_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      pcw       <= '0;
      pdiv_code <= '0;
      rate      <= '0;
      ref_q     <= '0;
      code_q    <= '0;
    end else begin
      done <= 1'b0;
      if (accept && zero_ref) begin
        err       <= 1'b1;
        pcw       <= '0;
        pdiv_code <= '0;
        rate      <= '0;
        done      <= 1'b1;
      end else if (div_load) begin
        busy   <= 1'b1;
        ref_q  <= ref_hz;
        code_q <= code_c;
      end else if (div_fin) begin
        busy      <= 1'b0;
        err       <= 1'b0;
        pcw       <= quot;
        pdiv_code <= code_q;
        rate      <= rate_c;
        done      <= 1'b1;
      end
    end
  end

  assert_code_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pdiv_code <= 3'(MAX_CODE));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !div_run));

  assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (pcw == '0 && rate == '0 && pdiv_code == '0));

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(ref_q) && $stable(code_q)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(pcw) && $stable(rate) && $stable(pdiv_code) && $stable(err)));

endmodule

// File: tb/pll_calc_bench.sv
`timescale 1ns/1ps
module pll_calc_bench;

  localparam logic [31:0] FMAX_B = 32'd2000000000;
  localparam logic [31:0] FMIN_B = 32'd1000000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] req_hz = '0;
  logic [31:0] ref_hz = '0;

  logic        busy_a, done_a, err_a, busy_b, done_b, err_b;
  logic [23:0] pcw_a;
  logic [6:0]  pcw_b;
  logic [2:0]  code_a, code_b;
  logic [63:0] rate_a, rate_b;

  int checks = 0;
  int errors = 0;
  int results = 0;

  always #2.5 clk = ~clk;

  pll_calc #(.PCW_W(24), .FMAX(FMAX_B), .FMIN_VCO(FMIN_B)) u_pll_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .req_hz(req_hz), .ref_hz(ref_hz),
    .busy(busy_a), .done(done_a), .err(err_a), .pcw(pcw_a), .pdiv_code(code_a), .rate(rate_a));

  pll_calc #(.PCW_W(7), .FMAX(FMAX_B), .FMIN_VCO(FMIN_B)) u_pll_calc_n (
    .clk(clk), .rst_n(rst_n), .start(start), .req_hz(req_hz), .ref_hz(ref_hz),
    .busy(busy_b), .done(done_b), .err(err_b), .pcw(pcw_b), .pdiv_code(code_b), .rate(rate_b));

  typedef struct {
    logic            err;
    int              code;
    longint unsigned pcw_a, rate_a, pcw_b, rate_b;
    string           tag;
  } exp_t;

  exp_t sb[$];

  task automatic check(input string req, input string what, input longint unsigned act,
                       input longint unsigned expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Independent restatement of R2..R6
  function automatic void model(input longint unsigned rq, input longint unsigned rf, input int pw,
                                output longint unsigned p, output longint unsigned r, output int c);
    longint unsigned f, vco, red, pd;
    int fr;
    f  = (rq > FMAX_B) ? FMAX_B : rq;
    c  = 4;
    for (int i = 0; i < 5; i++) begin
      if (f * (64'd1 << i) >= FMIN_B) begin c = i; break; end
    end
    fr  = (pw > 7) ? pw - 7 : 0;
    p   = ((f * (64'd1 << c)) * (64'd1 << fr)) / rf;
    p   = p % (64'd1 << pw);
    vco = rf * p;
    red = vco / (64'd1 << fr);
    if (vco % (64'd1 << fr) != 0) red = red + 1;
    pd  = 64'd1 << c;
    r   = (red + pd - 1) / pd;
  endfunction

  task automatic run(input logic [31:0] rq, input logic [31:0] rf, input string tag);
    exp_t e;
    e.tag = tag;
    if (rf == 0) begin
      e.err = 1'b1; e.code = 0; e.pcw_a = 0; e.rate_a = 0; e.pcw_b = 0; e.rate_b = 0;
    end else begin
      int cb;
      e.err = 1'b0;
      model(rq, rf, 24, e.pcw_a, e.rate_a, e.code);
      model(rq, rf, 7,  e.pcw_b, e.rate_b, cb);
    end
    sb.push_back(e);
    @(negedge clk);
    req_hz = rq; ref_hz = rf; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: pops one expected item per done strobe
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_a && prev_done) check("R7", "done wider than one cycle", 1, 0);
      if (done_a) begin
        results++;
        check("R7", "instances finish together", done_b, 1);
        check("R7", "busy low with done", busy_a, 0);
        if (sb.size() == 0) check("R9", "unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check("R8", {e.tag, " err"}, err_a, e.err);
          check("R3", {e.tag, " pdiv_code"}, code_a, e.code);
          check("R4", {e.tag, " pcw w24"}, pcw_a, e.pcw_a);
          check("R5", {e.tag, " rate w24"}, rate_a, e.rate_a);
          check("R4", {e.tag, " pcw w7"}, pcw_b, e.pcw_b);
          check("R6", {e.tag, " rate w7"}, rate_b, e.rate_b);
        end
      end
    end
    prev_done <= done_a;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    logic [23:0] hp;
    logic [63:0] hr;
    repeat (3) @(negedge clk);
    check("R1", "done", done_a, 0);
    check("R1", "busy", busy_a, 0);
    check("R1", "err", err_a, 0);
    check("R1", "pcw", pcw_a, 0);
    check("R1", "pdiv_code", code_a, 0);
    check("R1", "rate", rate_a, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(32'd1500000000, 32'd26000000, "R3 code0");
    run(32'd600000000,  32'd26000000, "R3 code1");
    run(32'd100000000,  32'd26000000, "R3 code4");
    run(32'd50000000,   32'd26000000, "R3 below floor");
    run(32'd1000000000, 32'd26000000, "R3 exact 1x");
    run(32'd500000000,  32'd26000000, "R3 exact 2x");
    run(32'd250000000,  32'd26000000, "R3 exact 4x");
    run(32'd125000000,  32'd26000000, "R3 exact 8x");
    run(32'd62500000,   32'd26000000, "R3 exact 16x");
    run(32'd3000000000, 32'd26000000, "R2 clamp");
    run(32'd2000000000, 32'd25000000, "R2 at max");
    run(32'd1234567891, 32'd1000003,  "R5 small ref");
    run(32'd777777777,  32'd19200000, "R6 ceil");
    run(32'd900000000,  32'd0,        "R8 zero ref");

    // R8: zero-reference result arrives the cycle after start
    @(negedge clk);
    req_hz = 32'd1500000000; ref_hz = 32'd0; start = 1'b1;
    begin exp_t e; e.err = 1; e.code = 0; e.pcw_a = 0; e.rate_a = 0; e.pcw_b = 0; e.rate_b = 0;
      e.tag = "R8 latency"; sb.push_back(e); end
    @(negedge clk);
    start = 1'b0;
    check("R8", "done one cycle after start", done_a, 1);
    repeat (2) @(negedge clk);

    // R9: second start while busy must be ignored
    begin
      exp_t e; int cb;
      e.err = 0; e.tag = "R9 first request kept";
      model(32'd1500000000, 32'd26000000, 24, e.pcw_a, e.rate_a, e.code);
      model(32'd1500000000, 32'd26000000, 7,  e.pcw_b, e.rate_b, cb);
      sb.push_back(e);
    end
    n0 = results;
    @(negedge clk);
    req_hz = 32'd1500000000; ref_hz = 32'd26000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7", "busy after start", busy_a, 1);
    repeat (10) @(negedge clk);
    req_hz = 32'd70000000; ref_hz = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy_a) @(negedge clk);
    repeat (80) @(negedge clk);
    check("R9", "one done for two starts", results - n0, 1);

    // R10: outputs hold while inputs move without start
    hp = pcw_a; hr = rate_a;
    req_hz = 32'd5; ref_hz = 32'd7;
    repeat (20) @(negedge clk);
    check("R10", "pcw held", pcw_a, hp);
    check("R10", "rate held", rate_a, hr);
    check("R10", "no done without start", done_a, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule